// File: doc/BRIEF.md
# PDM Self-Test Pattern Generator

This block produces a single-bit pulse-density stream so that a PDM receiver can be tested without a microphone attached. A stereo PDM link carries two channels on one wire: one is valid while the PDM clock is high and the other while it is low. The generator therefore keeps two independent sources, one per clock phase. Each source has its own pattern mode and its own drive delay.

The block runs on the fast interface clock. It observes a level copy of the PDM clock and counts interface-clock cycles from each rising edge of that clock. When the count reaches a phase's delay setting, that phase's next bit is loaded into the output register. The patterns are constant zero, constant one, an alternating bit, and a sine tone. The tone comes from a shared coupled-form oscillator that advances once per PDM period. Each phase turns it into bits with its own first-order sigma-delta modulator. The tone frequency is f_pdm / (2π·2^k), where k is the divide setting clamped into 3..13.

A typical configuration is a high-phase delay of 0 and a low-phase delay of 4, with both phases in sine mode and a divide setting of 7. The generator is held off until it is enabled.

Top module: `pdm_test_gen`

## Requirements
- R1: After reset data_o is 0. While en_i is low, data_o is 0 from the next clk_i edge on. Every pattern state returns to its start value: oscillator seed, modulator accumulators 0, alternating state 0. Mode and delay inputs have no effect while en_i is low.
- R2: Let E be the clk_i edge at which pdm_clk_i is first sampled high after being sampled low. The high-phase bit appears on data_o at edge E+dly_hi_i+1 and the low-phase bit at edge E+dly_lo_i+1. data_o holds its value at every other edge.
- R3: Mode code 0 loads a 0 and mode code 1 loads a 1 at that phase's drive point.
- R4: Mode code 2 loads the phase's alternating state and then inverts it. The state starts at 0 after enable, so the first bit is 0. It is held while the phase is in any other mode.
- R5: The two phases choose their bits independently from mode_hi_i and mode_lo_i. When both delays are equal, the low-phase bit is the one loaded.
- R6: The oscillator keeps signed 18-bit values x and y, seeded to x=65536 and y=0 while disabled. At each enabled edge E it computes x' = x - (y >>> k) and then y' = y + (x' >>> k).
- R7: k equals div_i when div_i is in 3..13. A div_i below 3 acts as 3 and a div_i above 13 acts as 13.
- R8: Mode code 3 uses a per-phase signed 20-bit accumulator a. At a drive point it forms v = a + x, loads bit = (v >= 0), and sets a to v - 131072 when the bit is 1 or v + 131072 when it is 0. The accumulator is held when the phase is in another mode.
- R9: If the PDM clock stops, the cycle counter saturates and never wraps. No further drive points occur, and data_o stays constant however long the pause lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generator enable |
| pdm_clk_i | input | 1 | PDM clock level, sampled on clk_i |
| mode_hi_i | input | 2 | Pattern mode for the high phase |
| mode_lo_i | input | 2 | Pattern mode for the low phase |
| dly_hi_i | input | DLY_W | High-phase drive delay in clk_i cycles minus one |
| dly_lo_i | input | DLY_W | Low-phase drive delay in clk_i cycles minus one |
| div_i | input | DIV_W | Tone divide exponent |
| data_o | output | 1 | Generated PDM bit |

## Verification
The assertions assume that pdm_clk_i is already synchronous to clk_i. They also assume the configuration changes only where the block's timing rules permit. The stimulus meets this with a PDM clock of eight interface cycles, four high and four low, driven on falling clk_i edges. Delays stay between 0 and 6, so no drive point collides with the next rising edge. Configuration changes only in the cycle that produces a rising edge, or while the generator is paused or disabled. Any drive point in that cycle has therefore already used the previous settings.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  typedef enum logic [1:0] {
    PAT_ZERO = 2'd0,
    PAT_ONE  = 2'd1,
    PAT_ALT  = 2'd2,
    PAT_SINE = 2'd3
  } pat_mode_e;

  localparam int unsigned NPH     = 2;
  localparam int unsigned PH_HI   = 0;
  localparam int unsigned PH_LO   = 1;
  localparam int unsigned DIV_MIN = 3;
  localparam int unsigned DIV_MAX = 13;
endpackage

// File: rtl/ptg_edge_timer.sv
module ptg_edge_timer #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pdm_clk_i,
  input  logic [DLY_W-1:0] dly_hi_i,
  input  logic [DLY_W-1:0] dly_lo_i,
  output logic             rise_o,
  output logic             stb_hi_o,
  output logic             stb_lo_o
);
  localparam int unsigned CNT_W = DLY_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             pdm_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  assign rise_o = en_i & pdm_clk_i & ~pdm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pdm_q <= 1'b1;
    else         pdm_q <= pdm_clk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!en_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (rise_o) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q && cnt_q != CNT_MAX) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // the spare top bit keeps a saturated count from matching any delay
  assign stb_hi_o = en_i & armed_q & (cnt_q == {1'b0, dly_hi_i});
  assign stb_lo_o = en_i & armed_q & (cnt_q == {1'b0, dly_lo_i});

  assert_rise_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> (cnt_q == '0) && armed_q);
  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && armed_q && !rise_o && cnt_q != CNT_MAX |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_cnt_sat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !rise_o && cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);
  assert_sat_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == CNT_MAX |-> !stb_hi_o && !stb_lo_o);
endmodule

// File: rtl/ptg_sine_osc.sv
module ptg_sine_osc
  import ptg_pkg::*;
#(
  parameter int unsigned OSC_W = 18,
  parameter int unsigned DIV_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    step_i,
  input  logic [DIV_W-1:0]        div_i,
  output logic signed [OSC_W-1:0] sin_o
);
  localparam logic signed [OSC_W-1:0] SEED = OSC_W'(2 ** (OSC_W - 2));

  logic signed [OSC_W-1:0] x_q, y_q, x_nx;
  logic [DIV_W-1:0]        k;

  always_comb begin
    if (32'(div_i) < DIV_MIN)      k = DIV_W'(DIV_MIN);
    else if (32'(div_i) > DIV_MAX) k = DIV_W'(DIV_MAX);
    else                           k = div_i;
  end

  // cross terms scaled by 2^-k: rotation of about 2^-k rad per step
  assign x_nx = x_q - (y_q >>> k);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= SEED;
      y_q <= '0;
    end else if (!en_i) begin
      x_q <= SEED;
      y_q <= '0;
    end else if (step_i) begin
      x_q <= x_nx;
      y_q <= y_q + (x_nx >>> k);
    end
  end

  assign sin_o = x_q;

  assert_seed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> x_q == SEED && y_q == '0);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !step_i |=> $stable(x_q) && $stable(y_q));
endmodule

// File: rtl/ptg_phase_src.sv
module ptg_phase_src
  import ptg_pkg::*;
#(
  parameter int unsigned OSC_W = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    stb_i,
  input  logic [1:0]              mode_i,
  input  logic signed [OSC_W-1:0] sin_i,
  output logic                    bit_o
);
  localparam int unsigned ACC_W = OSC_W + 2;
  localparam logic signed [ACC_W-1:0] FS = ACC_W'(2 ** (OSC_W - 1));

  pat_mode_e               mode;
  logic                    alt_q;
  logic signed [ACC_W-1:0] acc_q, sum;
  logic                    sd_bit;

  assign mode   = pat_mode_e'(mode_i);
  assign sum    = acc_q + ACC_W'(sin_i);
  assign sd_bit = ~sum[ACC_W-1];

  always_comb begin
    unique case (mode)
      PAT_ZERO: bit_o = 1'b0;
      PAT_ONE:  bit_o = 1'b1;
      PAT_ALT:  bit_o = alt_q;
      default:  bit_o = sd_bit;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alt_q <= 1'b0;
      acc_q <= '0;
    end else if (!en_i) begin
      alt_q <= 1'b0;
      acc_q <= '0;
    end else if (stb_i) begin
      if (mode == PAT_ALT)  alt_q <= ~alt_q;
      if (mode == PAT_SINE) acc_q <= sd_bit ? sum - FS : sum + FS;
    end
  end

  assert_state_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !stb_i |=> $stable(acc_q) && $stable(alt_q));
  assert_alt_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && stb_i && mode == PAT_ALT |=> alt_q != $past(alt_q));
endmodule

// File: rtl/pdm_test_gen.sv
module pdm_test_gen
  import ptg_pkg::*;
#(
  parameter int unsigned DLY_W = 8,
  parameter int unsigned DIV_W = 4,
  parameter int unsigned OSC_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pdm_clk_i,
  input  logic [1:0]       mode_hi_i,
  input  logic [1:0]       mode_lo_i,
  input  logic [DLY_W-1:0] dly_hi_i,
  input  logic [DLY_W-1:0] dly_lo_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             data_o
);
  logic                    rise;
  logic [NPH-1:0]          stb_w;
  logic [NPH-1:0]          bit_w;
  logic [1:0]              mode_w [NPH];
  logic signed [OSC_W-1:0] sin_w;
  logic                    data_q;

  assign mode_w[PH_HI] = mode_hi_i;
  assign mode_w[PH_LO] = mode_lo_i;

  ptg_edge_timer #(.DLY_W(DLY_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .pdm_clk_i (pdm_clk_i),
    .dly_hi_i  (dly_hi_i),
    .dly_lo_i  (dly_lo_i),
    .rise_o    (rise),
    .stb_hi_o  (stb_w[PH_HI]),
    .stb_lo_o  (stb_w[PH_LO])
  );

  ptg_sine_osc #(.OSC_W(OSC_W), .DIV_W(DIV_W)) u_osc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .step_i (rise),
    .div_i  (div_i),
    .sin_o  (sin_w)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    ptg_phase_src #(.OSC_W(OSC_W)) u_src (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .stb_i  (stb_w[g]),
      .mode_i (mode_w[g]),
      .sin_i  (sin_w),
      .bit_o  (bit_w[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             data_q <= 1'b0;
    else if (!en_i)          data_q <= 1'b0;
    else if (stb_w[PH_LO])   data_q <= bit_w[PH_LO];
    else if (stb_w[PH_HI])   data_q <= bit_w[PH_HI];
  end

  assign data_o = data_q;

  assert_off_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !data_o);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && stb_w == '0 |=> $stable(data_o));
  assert_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && stb_w[PH_HI] && !stb_w[PH_LO] && mode_hi_i == 2'd1 |=> data_o);
  assert_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && stb_w[PH_HI] && !stb_w[PH_LO] && mode_hi_i == 2'd0 |=> !data_o);
  assert_lo_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && stb_w[PH_LO] |=> data_o == $past(bit_w[PH_LO]));
endmodule

// File: tb/tb_pdm_test_gen.sv
module tb_pdm_test_gen;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, pdm = 1'b0;
  logic [1:0] mh = 2'd0, ml = 2'd0;
  logic [7:0] dh = 8'd0, dl = 8'd4;
  logic [3:0] dv = 4'd7;
  logic dout;

  always #(CLK_P/2) clk = ~clk;

  pdm_test_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pdm_clk_i(pdm),
    .mode_hi_i(mh), .mode_lo_i(ml), .dly_hi_i(dh), .dly_lo_i(dl),
    .div_i(dv), .data_o(dout)
  );

  int checks = 0, errors = 0;
  bit    exp_q[$];
  string tag_q[$];

  logic signed [17:0] mx, my;
  logic signed [19:0] macc [2];
  logic               malt [2];
  logic               mout;

  function automatic int k_of(input logic [3:0] d);
    if (d < 4'd3)  return 3;
    if (d > 4'd13) return 13;
    return int'(d);
  endfunction

  task automatic model_reset();
    mx = 18'sd65536; my = '0;
    macc[0] = '0; macc[1] = '0;
    malt[0] = 1'b0; malt[1] = 1'b0;
    mout = 1'b0;
  endtask

  task automatic model_osc(input logic [3:0] d);
    logic signed [17:0] xn;
    int k;
    k  = k_of(d);
    xn = mx - (my >>> k);
    my = my + (xn >>> k);
    mx = xn;
  endtask

  task automatic model_phase(input int ph, input logic [1:0] m);
    logic signed [19:0] v;
    case (m)
      2'd0: mout = 1'b0;
      2'd1: mout = 1'b1;
      2'd2: begin mout = malt[ph]; malt[ph] = ~malt[ph]; end
      default: begin
        v = macc[ph] + 20'(mx);
        mout = (v >= 0);
        macc[ph] = mout ? v - 20'sd131072 : v + 20'sd131072;
      end
    endcase
  endtask

  task automatic push(input string tag);
    exp_q.push_back(mout);
    tag_q.push_back(tag);
  endtask

  // one PDM period: 4 cycles high, 4 low; config applied on the rising cycle
  task automatic run_period(input logic [1:0] mh_n, input logic [1:0] ml_n,
                            input logic [7:0] dh_n, input logic [7:0] dl_n,
                            input logic [3:0] dv_n, input string tag);
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      if (p == 0) begin mh = mh_n; ml = ml_n; dh = dh_n; dl = dl_n; dv = dv_n; end
      pdm = (p < 4);
      if (p == 0) model_osc(dv);
      if (p == int'(dh) + 1) model_phase(0, mh);
      if (p == int'(dl) + 1) model_phase(1, ml);
      push(tag);
    end
  endtask

  task automatic run_n(input int n, input logic [1:0] mh_n, input logic [1:0] ml_n,
                       input logic [7:0] dh_n, input logic [7:0] dl_n,
                       input logic [3:0] dv_n, input string tag);
    for (int i = 0; i < n; i++) run_period(mh_n, ml_n, dh_n, dl_n, dv_n, tag);
  endtask

  task automatic stall(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pdm = 1'b0;
      push(tag);
    end
  endtask

  task automatic set_en(input logic v, input string tag);
    @(negedge clk);
    en = v; pdm = 1'b0;
    if (!v) model_reset();
    push(tag);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // scoreboard monitor
  initial begin
    bit    e;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (dout !== e) begin
          errors++;
          $display("FAIL %s: data_o=%0b expected %0b at %0t", t, dout, e, $time);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run incomplete, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (dout !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: data_o=%0b expected 0", dout);
    end

    // R1: modes ignored while disabled
    mh = 2'd1; ml = 2'd1;
    stall(20, "R1");
    set_en(1'b1, "R1");
    // R3 constants, default-like delays
    run_n(3, 2'd1, 2'd0, 8'd0, 8'd4, 4'd7, "R3");
    run_n(3, 2'd0, 2'd1, 8'd0, 8'd4, 4'd7, "R3");
    // R2 other drive points
    run_n(3, 2'd0, 2'd1, 8'd2, 8'd5, 4'd7, "R2");
    run_n(3, 2'd1, 2'd0, 8'd1, 8'd6, 4'd7, "R2");
    // R4 alternating, hold in other mode, resume
    run_n(6, 2'd2, 2'd1, 8'd1, 8'd6, 4'd7, "R4");
    run_n(2, 2'd1, 2'd1, 8'd1, 8'd6, 4'd7, "R4");
    run_n(3, 2'd2, 2'd2, 8'd0, 8'd4, 4'd7, "R4");
    // R5 independence and equal delays
    run_n(2, 2'd1, 2'd0, 8'd3, 8'd3, 4'd7, "R5");
    run_n(2, 2'd0, 2'd1, 8'd3, 8'd3, 4'd7, "R5");
    run_n(2, 2'd2, 2'd1, 8'd0, 8'd5, 4'd7, "R5");
    // R9 stopped PDM clock longer than the counter range
    run_n(1, 2'd2, 2'd2, 8'd0, 8'd4, 4'd7, "R9");
    stall(600, "R9");
    run_n(2, 2'd2, 2'd2, 8'd0, 8'd4, 4'd7, "R9");
    // R1 disable clears, inputs ignored
    set_en(1'b0, "R1");
    mh = 2'd1; ml = 2'd1;
    stall(12, "R1");
    set_en(1'b1, "R1");
    // R8 / R6 tone
    run_n(60, 2'd3, 2'd3, 8'd0, 8'd4, 4'd3, "R8");
    run_n(40, 2'd3, 2'd2, 8'd1, 8'd5, 4'd5, "R6");
    // R7 clamping
    set_en(1'b0, "R1");
    set_en(1'b1, "R7");
    run_n(40, 2'd3, 2'd3, 8'd0, 8'd4, 4'd15, "R7");
    set_en(1'b0, "R1");
    set_en(1'b1, "R7");
    run_n(40, 2'd3, 2'd3, 8'd0, 8'd4, 4'd1, "R7");

    wait (exp_q.size() == 0);
    repeat (2) @(posedge clk);
    summary();
    $finish;
  end
endmodule